// File: doc/BRIEF.md
# Dual Time Base Generator

This block keeps two free-running 24-bit time bases that a bank of timer channels samples for synchronization. Each time base has its own clock-source selector and its own prescaler. The first time base can count system clock cycles through a divider with an even ratio, count rising edges of an external clock pin, or count output pulses of the second time base's prescaler. The second time base can count external clock edges, count a fixed system-clock-divided-by-8 tick, or act as a pulse accumulator. In accumulator mode it adds one for every system clock cycle in which a gate pin is high.

Configuration is written through a small register port. One write strobe, one select bit and one data word load either time base's source and divide field in a single cycle. A separate software-clear pin zeroes both counts and every prescaler state without touching the configuration. The external clock and the gate are asynchronous and pass through two-flop synchronizers before use. No data moves as a stream here: the count outputs are continuous levels that any number of readers may sample, so there is no valid/ready handshake and nothing can back-pressure the counters.

Top module: `dual_timebase`

## Requirements
- R1: During and after reset both counts are 0, and both time bases are stopped (source code 0) until configured.
- R2: A write with cfg_sel=0 loads time base 1 with source from cfg_data[1:0] and field F1 from cfg_data[9:2]. A write with cfg_sel=1 loads time base 2 with source from cfg_data[1:0] and field F2 from cfg_data[7:2]. The new setting governs counting from the next clock edge.
- R3: Time base 1 with source 1 (system clock) increments once every 2*(F1+1) system clock cycles.
- R4: Time base 1 with source 2 (external) increments once per F1+1 rising edges of ext_clk, counted after a two-flop synchronizer.
- R5: Time base 1 with source 3 (chained) increments once per F1+1 output pulses of time base 2's prescaler.
- R6: Time base 2 with source 1 (external) increments once per F2+1 synchronized rising edges of ext_clk.
- R7: Time base 2 with source 2 increments once per F2+1 ticks of a system-clock-divided-by-8 divider, that is every 8*(F2+1) cycles.
- R8: Time base 2 with source 3 (accumulator) adds exactly one on each clock edge at which the two-flop synchronized gate is high, and its prescaler is bypassed.
- R9: Both counts wrap from all ones to 0 and otherwise never change by anything but +1 outside a software clear.
- R10: sw_clr high at a clock edge zeroes both counts, both prescalers and the divide-by-8 divider, and leaves the configuration unchanged.
- R11: A time base with source 0 holds its count regardless of ext_clk and gate activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_clr | input | 1 | Software clear of counts and prescalers |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects time base 1, 1 selects time base 2 |
| cfg_data | input | 10 | Source code [1:0] and divide field [9:2] or [7:2] |
| ext_clk | input | 1 | Asynchronous external clock |
| gate | input | 1 | Asynchronous accumulator gate |
| tb1_count | output | 24 | Time base 1 count |
| tb2_count | output | 24 | Time base 2 count |

## Verification
The bench goes after the even-ratio system clock path. A design that forgot the factor of two there would count twice as fast from the first prescaler period. It drives the chained mode alongside an external-clock time base 2, where a prescaler output taken one cycle late or on the wrong edge shifts time base 1 by a cycle. Accumulator mode runs with a pseudo-random gate and a narrow second instance, so a missed synchronizer stage, a prescaler left in the path or a saturating counter shows up as a count that differs, both during accumulation and where the count wraps. A software clear issued mid-period shows whether stale prescaler residue survives, because the next increment would then arrive early.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

  localparam int SRC_W = 2;

  typedef enum logic [SRC_W-1:0] {
    T1_OFF   = 2'd0,
    T1_SYS   = 2'd1,
    T1_EXT   = 2'd2,
    T1_CHAIN = 2'd3
  } tb1_src_e;

  typedef enum logic [SRC_W-1:0] {
    T2_OFF   = 2'd0,
    T2_EXT   = 2'd1,
    T2_FAST  = 2'd2,
    T2_GATED = 2'd3
  } tb2_src_e;

endpackage

// File: rtl/tbg_sync.sv
module tbg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/tbg_prescaler.sv
module tbg_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick_in,
  input  logic [W-1:0] lim,
  output logic         tick_out
);

  logic [W-1:0] cnt_q;

  // Terminal when the residue has reached the limit; >= keeps a shrunk
  // limit from stranding the residue above it.
  assign tick_out = tick_in && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (tick_in) cnt_q <= tick_out ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/tbg_counter.sv
module tbg_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (step) count <= count + 1'b1;
  end

endmodule

// File: rtl/dual_timebase.sv
module dual_timebase
  import dtb_pkg::*;
#(
  parameter int CNT_W         = 24,
  parameter int T1_FLD_W      = 8,
  parameter int T2_FLD_W      = 6,
  parameter int SYNC_STAGES   = 2,
  parameter int FAST_DIV_LOG2 = 3,
  localparam int CFG_W        = SRC_W + T1_FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clr,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             ext_clk,
  input  logic             gate,
  output logic [CNT_W-1:0] tb1_count,
  output logic [CNT_W-1:0] tb2_count
);

  localparam int P1_W = T1_FLD_W + 1;
  localparam int P2_W = T2_FLD_W;

  // configuration registers
  tb1_src_e              src1_q;
  tb2_src_e              src2_q;
  logic [T1_FLD_W-1:0]   fld1_q;
  logic [T2_FLD_W-1:0]   fld2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src1_q <= T1_OFF;
      src2_q <= T2_OFF;
      fld1_q <= '0;
      fld2_q <= '0;
    end else if (cfg_wr) begin
      if (!cfg_sel) begin
        src1_q <= tb1_src_e'(cfg_data[SRC_W-1:0]);
        fld1_q <= cfg_data[SRC_W +: T1_FLD_W];
      end else begin
        src2_q <= tb2_src_e'(cfg_data[SRC_W-1:0]);
        fld2_q <= cfg_data[SRC_W +: T2_FLD_W];
      end
    end
  end

  // input conditioning
  logic ext_s, ext_d, ext_rise, gate_s;

  tbg_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(ext_s)
  );

  tbg_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .d(gate), .q(gate_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_d <= 1'b0;
    else        ext_d <= ext_s;
  end

  assign ext_rise = ext_s & ~ext_d;

  // fixed fast divider for time base 2
  logic [FAST_DIV_LOG2-1:0] fdiv_q;
  logic                     fast_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fdiv_q <= '0;
    else if (sw_clr) fdiv_q <= '0;
    else             fdiv_q <= fdiv_q + 1'b1;
  end

  assign fast_tick = &fdiv_q;

  // time base 2 prescaler and step
  logic            t2_in, t2_pre, t2_step;
  logic [P2_W-1:0] lim2;

  assign lim2 = fld2_q;

  always_comb begin
    unique case (src2_q)
      T2_EXT:  t2_in = ext_rise;
      T2_FAST: t2_in = fast_tick;
      default: t2_in = 1'b0;
    endcase
  end

  tbg_prescaler #(.W(P2_W)) u_pre2 (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr),
    .tick_in(t2_in), .lim(lim2), .tick_out(t2_pre)
  );

  assign t2_step = (src2_q == T2_GATED) ? gate_s : t2_pre;

  // time base 1 prescaler and step
  logic            t1_in, t1_step;
  logic [P1_W-1:0] lim1;

  // system clock path divides by 2*(F+1): limit is 2F+1
  assign lim1 = (src1_q == T1_SYS) ? {fld1_q, 1'b1} : {1'b0, fld1_q};

  always_comb begin
    unique case (src1_q)
      T1_SYS:   t1_in = 1'b1;
      T1_EXT:   t1_in = ext_rise;
      T1_CHAIN: t1_in = t2_pre;
      default:  t1_in = 1'b0;
    endcase
  end

  tbg_prescaler #(.W(P1_W)) u_pre1 (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr),
    .tick_in(t1_in), .lim(lim1), .tick_out(t1_step)
  );

  // counters
  tbg_counter #(.W(CNT_W)) u_cnt1 (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .step(t1_step), .count(tb1_count)
  );

  tbg_counter #(.W(CNT_W)) u_cnt2 (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .step(t2_step), .count(tb2_count)
  );

endmodule

// File: rtl/dual_timebase_chk.sv
module dual_timebase_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_clr,
  input logic [1:0]       src1,
  input logic [1:0]       src2,
  input logic             gate_s,
  input logic [CNT_W-1:0] t1,
  input logic [CNT_W-1:0] t2
);

  // R10
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> (t1 == '0) && (t2 == '0));

  // R9
  tb1_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_clr) |-> (t1 == $past(t1)) || (t1 == CNT_W'($past(t1) + 1'b1)));

  // R9
  tb2_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_clr) |-> (t2 == $past(t2)) || (t2 == CNT_W'($past(t2) + 1'b1)));

  // R11
  tb1_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src1) == 2'd0 && !$past(sw_clr)) |-> $stable(t1));

  // R8
  gated_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src2) == 2'd3 && !$past(sw_clr))
      |-> (t2 == CNT_W'($past(t2) + $past(gate_s))));

  // R3
  sys_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src1) == 2'd1 && $past(src1, 2) == 2'd1 && !$past(sw_clr) && !$past(sw_clr, 2)
      && t1 != $past(t1)) |-> ($past(t1) == $past(t1, 2)));

endmodule

bind dual_timebase dual_timebase_chk #(.CNT_W(CNT_W)) u_dual_timebase_chk (
  .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr),
  .src1(src1_q), .src2(src2_q), .gate_s(gate_s),
  .t1(tb1_count), .t2(tb2_count)
);

// File: tb/test_dual_timebase.sv
module test_dual_timebase;

  localparam int WD_CYCLES = 50000;
  localparam int NARROW_W  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_clr = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [9:0]  cfg_data = '0;
  logic        ext_clk = 1'b0;
  logic        gate = 1'b0;
  logic [23:0] tb1_count, tb2_count;
  logic [NARROW_W-1:0] n1_count, n2_count;

  always #5 clk = ~clk;

  dual_timebase i_dual_timebase (
    .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .ext_clk(ext_clk), .gate(gate),
    .tb1_count(tb1_count), .tb2_count(tb2_count)
  );

  // narrow copy so wrap-around is reachable in a short run
  dual_timebase #(.CNT_W(NARROW_W)) i_narrow (
    .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .ext_clk(ext_clk), .gate(gate),
    .tb1_count(n1_count), .tb2_count(n2_count)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  string cur_req  = "R1";

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int     m_src1, m_src2, m_f1, m_f2;
  int     m_p1, m_p2, m_fast;
  longint m_c1, m_c2;
  bit     e_pipe[$];
  bit     g_pipe[$];
  bit     e_last;

  initial begin
    e_pipe = '{0, 0};
    g_pipe = '{0, 0};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src1 = 0; m_src2 = 0; m_f1 = 0; m_f2 = 0;
      m_p1 = 0; m_p2 = 0; m_fast = 0; m_c1 = 0; m_c2 = 0;
      e_pipe = '{0, 0}; g_pipe = '{0, 0}; e_last = 0;
    end else begin
      bit rise, g_on, fast, in2, pre2, step2, in1, step1;
      int ratio1;
      rise  = e_pipe[1] && !e_last;
      g_on  = g_pipe[1];
      fast  = (m_fast == 7);
      in2   = (m_src2 == 1) ? rise : (m_src2 == 2) ? fast : 1'b0;
      pre2  = in2 && (m_p2 + 1 >= m_f2 + 1);
      step2 = (m_src2 == 3) ? g_on : pre2;
      in1   = (m_src1 == 1) ? 1'b1 : (m_src1 == 2) ? rise : (m_src1 == 3) ? pre2 : 1'b0;
      ratio1 = (m_src1 == 1) ? 2 * (m_f1 + 1) : m_f1 + 1;
      step1 = in1 && (m_p1 + 1 >= ratio1);
      if (sw_clr) begin
        m_p1 = 0; m_p2 = 0; m_fast = 0; m_c1 = 0; m_c2 = 0;
      end else begin
        m_fast = (m_fast + 1) % 8;
        if (in2) m_p2 = pre2 ? 0 : m_p2 + 1;
        if (in1) m_p1 = step1 ? 0 : m_p1 + 1;
        if (step2) m_c2++;
        if (step1) m_c1++;
      end
      if (cfg_wr) begin
        if (!cfg_sel) begin m_src1 = cfg_data[1:0]; m_f1 = cfg_data[9:2]; end
        else          begin m_src2 = cfg_data[1:0]; m_f2 = cfg_data[7:2]; end
      end
      e_last = e_pipe[1];
      e_pipe.push_front(ext_clk); void'(e_pipe.pop_back());
      g_pipe.push_front(gate);    void'(g_pipe.pop_back());
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "tb1", tb1_count, m_c1 % (longint'(1) << 24));
      chk(cur_req, "tb2", tb2_count, m_c2 % (longint'(1) << 24));
      chk(cur_req, "narrow tb1", n1_count, m_c1 % (longint'(1) << NARROW_W));
      chk(cur_req, "narrow tb2", n2_count, m_c2 % (longint'(1) << NARROW_W));
    end
  end

  // ---------------- stimulus generators ----------------
  int       ext_half = 0;
  int       gate_mode = 0;  // 0 low, 1 high, 2 pseudo-random
  int       stim_cyc = 0;
  bit [7:0] lfsr = 8'hA5;

  always @(negedge clk) begin
    stim_cyc++;
    if (ext_half != 0 && (stim_cyc % ext_half) == 0) ext_clk <= ~ext_clk;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    gate <= (gate_mode == 1) ? 1'b1 : (gate_mode == 2) ? lfsr[0] : 1'b0;
  end

  task automatic wr(input bit sel, input int src, input int fld);
    @(negedge clk);
    cfg_wr   <= 1'b1;
    cfg_sel  <= sel;
    cfg_data <= {fld[7:0], src[1:0]};
    @(negedge clk);
    cfg_wr   <= 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr;
    @(negedge clk);
    sw_clr <= 1'b1;
    @(negedge clk);
    sw_clr <= 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // ---------------- sequence ----------------
  initial begin
    cur_req = "R1";
    run(4);
    chk("R1", "tb1 in reset", tb1_count, 0);
    chk("R1", "tb2 in reset", tb2_count, 0);
    @(negedge clk) rst_n <= 1'b1;
    ext_half = 3;
    run(20);
    chk("R1", "tb1 unconfigured", tb1_count, 0);
    chk("R11", "tb2 unconfigured", tb2_count, 0);

    cur_req = "R3";
    wr(0, 1, 2);           // R2 encoding: source 1, F1=2 -> /6
    run(120);
    cur_req = "R3";
    wr(0, 1, 0);           // /2
    run(60);

    cur_req = "R4";
    wr(0, 2, 1);           // external, /2
    run(200);

    cur_req = "R6";
    wr(1, 1, 2);           // time base 2 external /3
    cur_req = "R5";
    wr(0, 3, 1);           // chained, /2
    run(400);

    cur_req = "R10";
    run(7);
    pulse_clr();
    chk("R10", "tb1 after clear", tb1_count, 0);
    chk("R10", "tb2 after clear", tb2_count, 0);
    run(200);

    cur_req = "R7";
    wr(1, 2, 1);           // fast divider /2 -> every 16 cycles
    run(300);

    cur_req = "R11";
    wr(0, 0, 5);
    run(100);

    cur_req = "R8";
    gate_mode = 1;
    wr(1, 3, 9);           // accumulator, field ignored
    run(150);              // narrow copy wraps
    gate_mode = 2;
    run(300);
    cur_req = "R9";
    gate_mode = 1;
    run(80);

    cur_req = "R11";
    gate_mode = 2;
    wr(1, 0, 0);
    run(100);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog %s actual running expected finished", cur_req);
      report();
      $finish;
    end
  end

endmodule